// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Sequencer

This block sits between a simple synchronous request port and an asynchronous dynamic memory whose row and column addresses share one set of address pins. Each accepted request is one word access. The block splits the flat address into a row half and a column half. It then steps through a fixed sequence of phases: row setup, row strobe low, column setup, column strobe low, and precharge. Every phase length except column setup is a parameter counted in clock cycles.

For a write, the block drives its data onto the shared data bus through a tri-state enable, and only during the column phase. For a read, it releases the bus and pulls output enable low while the column strobe is low. It samples the returning word on the clock edge that ends the column pulse, then presents that word together with a one-cycle valid pulse. The request port stays not-ready from the moment a request is accepted until precharge has finished. The precharge spacing therefore holds even when requests arrive back to back.

Top module: `dram_seq`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an access, row strobe, column strobe, write enable and output enable are all high, the data-bus drive enable is low, read valid is low and the request port is ready.
- R2: The row half of the address is on the address pins, unchanged from the previous cycle, in the cycle the row strobe falls. The row strobe stays low in every cycle in which the column strobe is low.
- R3: The flat address is split so that its upper ADDR_W-ADDR_W/2 bits are the row and its lower ADDR_W/2 bits are the column. The column half is on the address pins, unchanged from the previous cycle, when the column strobe falls.
- R4: Write enable is low at the column strobe falling edge for a write and high for a read, and it does not change while the column strobe is low.
- R5: For a write, the data-bus drive enable is high and the request's write data is on the bus when the column strobe falls, and output enable stays high throughout the access. For a read, the drive enable stays low.
- R6: For a read, output enable is low while the column strobe is low. The bus is sampled on the edge that ends the column pulse, and the sampled word appears on the read data output with read valid high for exactly one cycle, T_ROW_SETUP+T_ROW_TO_COL+1+T_COL_PULSE cycles after the accepting edge. Writes produce no read valid.
- R7: After the column strobe rises, both strobes stay high for T_PRECHARGE cycles before the request port is ready again. With a request held valid, consecutive accepts are T_ROW_SETUP+T_ROW_TO_COL+T_COL_PULSE+T_PRECHARGE+2 cycles apart.
- R8: The row strobe falls T_ROW_SETUP cycles after the accepting edge. The column strobe falls T_ROW_TO_COL+1 cycles after the row strobe falls, and it stays low for T_COL_PULSE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Flat word address |
| reqWdata | input | DATA_W | Write data |
| rdValid | output | 1 | One-cycle pulse with read data |
| rdData | output | DATA_W | Word sampled from the bus |
| memAddr | output | ADDR_W-ADDR_W/2 | Shared row/column address pins |
| rowStrobeN | output | 1 | Row strobe, active low |
| colStrobeN | output | 1 | Column strobe, active low |
| writeEnN | output | 1 | Write enable, active low |
| outEnN | output | 1 | Output enable, active low |
| dqOut | output | DATA_W | Data driven toward the bus |
| dqOutEn | output | 1 | Tri-state enable for dqOut |
| dqIn | input | DATA_W | Data seen on the bus |

## Verification
The bench places a behavioural memory on the pins that latches row and column on strobe falling edges and drives the bus only under the read gating. It exercises the block with writes and reads at address 0x00 and 0xFF, and with the mirror pair 0x5A and 0xA5. A swapped or mis-split row/column half shows up in that mirror pair as crossed data. An overwrite followed by a read-back separates a real write from stale data, and a read of a location never written must return zero. A held-valid back-to-back pair measures the precharge spacing. A reset during a read's column pulse shows whether the strobes return high at once.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Command word from the sequencing control to the datapath.
  typedef struct packed {
    logic rowStrobeN;
    logic colStrobeN;
    logic writeEnN;
    logic outEnN;
    logic selCol;
    logic driveData;
    logic accept;
    logic capture;
  } seqCmd_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ROW    = 3'd1,
    PH_RCD    = 3'd2,
    PH_COLSET = 3'd3,
    PH_CAS    = 3'd4,
    PH_PRE    = 3'd5
  } seqPhase_e;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int T_ROW_SETUP  = 2,
  parameter int T_ROW_TO_COL = 2,
  parameter int T_COL_PULSE  = 3,
  parameter int T_PRECHARGE  = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output seqCmd_t cmd
);

  localparam int MAX_A = (T_ROW_SETUP > T_ROW_TO_COL) ? T_ROW_SETUP : T_ROW_TO_COL;
  localparam int MAX_B = (T_COL_PULSE > T_PRECHARGE) ? T_COL_PULSE : T_PRECHARGE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;

  localparam logic [CNT_W-1:0] LD_ROW = CNT_W'(T_ROW_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_ROW_TO_COL - 1);
  localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_COL_PULSE - 1);
  localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(T_PRECHARGE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_T - 1);

  seqPhase_e        phase;
  logic [CNT_W-1:0] cnt;
  logic             wrFlag;
  logic             phaseDone;

  assign phaseDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      wrFlag <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase  <= PH_ROW;
            cnt    <= LD_ROW;
            wrFlag <= reqWrite;
          end
        end
        PH_ROW: begin
          if (!phaseDone) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_RCD;
            cnt   <= LD_RCD;
          end
        end
        PH_RCD: begin
          if (!phaseDone) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_COLSET;
            cnt   <= '0;
          end
        end
        PH_COLSET: begin
          phase <= PH_CAS;
          cnt   <= LD_CAS;
        end
        PH_CAS: begin
          if (!phaseDone) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_PRE;
            cnt   <= LD_PRE;
          end
        end
        PH_PRE: begin
          if (!phaseDone) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  logic rowOpen;
  logic colPhase;

  always_comb begin
    rowOpen  = (phase == PH_RCD) || (phase == PH_COLSET) || (phase == PH_CAS);
    colPhase = (phase == PH_COLSET) || (phase == PH_CAS);

    cmd.rowStrobeN = ~rowOpen;
    cmd.colStrobeN = ~(phase == PH_CAS);
    cmd.writeEnN   = ~(wrFlag && colPhase);
    cmd.outEnN     = ~(!wrFlag && (phase == PH_CAS));
    cmd.selCol     = colPhase;
    cmd.driveData  = wrFlag && colPhase;
    cmd.accept     = (phase == PH_IDLE) && reqValid;
    cmd.capture    = (phase == PH_CAS) && phaseDone && !wrFlag;
    reqReady       = (phase == PH_IDLE);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX); // R8
  AST_CAS_AFTER_COLSET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CAS && $past(phase) != PH_CAS) |-> $past(phase) == PH_COLSET); // R8
  AST_WRFLAG_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(wrFlag)); // R4
  AST_READY_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_PRE && phase != PH_PRE) |-> reqReady); // R7

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int COL_W = ADDR_W / 2,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int PIN_W = ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [PIN_W-1:0]  memAddr,
  output logic              rowStrobeN,
  output logic              colStrobeN,
  output logic              writeEnN,
  output logic              outEnN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOutEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdataReg;
  logic [PIN_W-1:0]  colPin;

  always_ff @(posedge clk) begin
    if (rst) begin
      rowReg   <= '0;
      colReg   <= '0;
      wdataReg <= '0;
    end else if (cmd.accept) begin
      rowReg   <= reqAddr[ADDR_W-1:COL_W];
      colReg   <= reqAddr[COL_W-1:0];
      wdataReg <= reqWdata;
    end
  end

  generate
    if (PIN_W > COL_W) begin : g_colPad
      assign colPin = {{(PIN_W - COL_W){1'b0}}, colReg};
    end else begin : g_colExact
      assign colPin = colReg;
    end
  endgenerate

  assign memAddr    = cmd.selCol ? colPin : rowReg;
  assign rowStrobeN = cmd.rowStrobeN;
  assign colStrobeN = cmd.colStrobeN;
  assign writeEnN   = cmd.writeEnN;
  assign outEnN     = cmd.outEnN;
  assign dqOut      = wdataReg;
  assign dqOutEn    = cmd.driveData;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= cmd.capture;
      if (cmd.capture) rdData <= dqIn;
    end
  end

  AST_ROW_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(rowStrobeN) |-> $stable(memAddr)); // R2
  AST_ROW_HELD_OPEN: assert property (@(posedge clk) disable iff (rst)
    !colStrobeN |-> !rowStrobeN); // R2
  AST_COL_ADDR_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(colStrobeN) |-> $stable(memAddr)); // R3
  AST_WE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!colStrobeN && !$past(colStrobeN)) |-> $stable(writeEnN)); // R4
  AST_WDATA_AT_CAS: assert property (@(posedge clk) disable iff (rst)
    ($fell(colStrobeN) && !writeEnN) |-> (dqOutEn && $stable(dqOut))); // R5
  AST_OE_OFF_WRITE: assert property (@(posedge clk) disable iff (rst)
    !writeEnN |-> outEnN); // R5
  AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (rst)
    !outEnN |-> !dqOutEn); // R5
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid); // R6
  AST_RD_AT_CAS_END: assert property (@(posedge clk) disable iff (rst)
    $rose(rdValid) |-> ($rose(colStrobeN) && writeEnN)); // R6

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int T_ROW_SETUP  = 2,
  parameter int T_ROW_TO_COL = 2,
  parameter int T_COL_PULSE  = 3,
  parameter int T_PRECHARGE  = 3,
  localparam int PIN_W = ADDR_W - ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_W-1:0]  memAddr,
  output logic              rowStrobeN,
  output logic              colStrobeN,
  output logic              writeEnN,
  output logic              outEnN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOutEn,
  input  logic [DATA_W-1:0] dqIn
);

  seqCmd_t cmd;

  dram_seq_ctrl #(
    .T_ROW_SETUP (T_ROW_SETUP),
    .T_ROW_TO_COL(T_ROW_TO_COL),
    .T_COL_PULSE (T_COL_PULSE),
    .T_PRECHARGE (T_PRECHARGE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .cmd     (cmd)
  );

  dram_seq_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .dqIn      (dqIn),
    .memAddr   (memAddr),
    .rowStrobeN(rowStrobeN),
    .colStrobeN(colStrobeN),
    .writeEnN  (writeEnN),
    .outEnN    (outEnN),
    .dqOut     (dqOut),
    .dqOutEn   (dqOutEn),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (rowStrobeN && colStrobeN && !dqOutEn && outEnN)); // R7
  AST_BUSY_UNTIL_PRE: assert property (@(posedge clk) disable iff (rst)
    $rose(colStrobeN) |=> !reqReady); // R7

endmodule

// File: tb/tb_dram_seq.sv
module tb_dram_seq;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TRS = 2;
  localparam int TRCD = 2;
  localparam int TCAS = 3;
  localparam int TPRE = 3;
  localparam int CW = AW / 2;
  localparam int PW = AW - CW;
  localparam int RD_LAT = TRS + TRCD + 1 + TCAS;
  localparam int GAP = TRS + TRCD + TCAS + TPRE + 2;
  localparam int NVEC = 11;

  // {write, address, data (write data or expected read data)}
  localparam logic [24:0] VECS [0:NVEC-1] = '{
    {1'b1, 8'h00, 16'h1234},
    {1'b1, 8'hFF, 16'hBEEF},
    {1'b1, 8'h5A, 16'h0F0F},
    {1'b1, 8'hA5, 16'hF0F0},
    {1'b0, 8'h00, 16'h1234},
    {1'b0, 8'hFF, 16'hBEEF},
    {1'b0, 8'h5A, 16'h0F0F},
    {1'b0, 8'hA5, 16'hF0F0},
    {1'b1, 8'h5A, 16'h7777},
    {1'b0, 8'h5A, 16'h7777},
    {1'b0, 8'h3C, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rdValid, rowStrobeN, colStrobeN, writeEnN, outEnN, dqOutEn;
  logic [DW-1:0] rdData, dqOut, dqIn;
  logic [PW-1:0] memAddr;

  always #5 clk = ~clk;

  dram_seq #(
    .ADDR_W(AW), .DATA_W(DW),
    .T_ROW_SETUP(TRS), .T_ROW_TO_COL(TRCD), .T_COL_PULSE(TCAS), .T_PRECHARGE(TPRE)
  ) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN), .writeEnN(writeEnN),
    .outEnN(outEnN), .dqOut(dqOut), .dqOutEn(dqOutEn), .dqIn(dqIn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural memory on the pins
  logic [DW-1:0] mem [0:255];
  logic [PW-1:0] latRow = '0;
  logic [CW-1:0] latCol = '0;
  logic memDrive;
  assign memDrive = !rowStrobeN && !colStrobeN && !outEnN && writeEnN;
  assign dqIn = memDrive ? mem[{latRow, latCol}] : '0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor state
  bit prevRas = 1, prevCas = 1, prevReady = 1, inFlight = 0, accFlag = 0;
  logic [PW-1:0] prevAddr = '0;
  int acceptAt = 0, prevAcceptAt = 0, lastGap = 0;
  bit curWr = 0;
  logic [AW-1:0] curAddr = '0;
  logic [DW-1:0] curData = '0;

  always @(negedge clk) begin
    if (rst) begin
      inFlight = 0;
      accFlag  = 0;
    end else begin
      if (prevRas && !rowStrobeN) begin
        check(memAddr == curAddr[AW-1:CW], "R2 row on pins", memAddr, curAddr[AW-1:CW]);
        check(memAddr == prevAddr, "R2 row stable", memAddr, prevAddr);
        check(cyc == acceptAt + TRS, "R8 row fall time", cyc, acceptAt + TRS);
        latRow = memAddr;
      end
      if (!colStrobeN)
        check(!rowStrobeN, "R2 row open during column", rowStrobeN, 0);
      if (prevCas && !colStrobeN) begin
        check(memAddr == PW'(curAddr[CW-1:0]), "R3 column on pins", memAddr, curAddr[CW-1:0]);
        check(memAddr == prevAddr, "R3 column stable", memAddr, prevAddr);
        check(writeEnN == !curWr, "R4 write enable", writeEnN, !curWr);
        check(cyc == acceptAt + TRS + TRCD + 1, "R8 column fall time", cyc,
              acceptAt + TRS + TRCD + 1);
        latCol = memAddr[CW-1:0];
        if (curWr) begin
          check(dqOutEn && dqOut == curData, "R5 write data on bus", dqOut, curData);
          mem[{latRow, latCol}] = dqOut;
        end else begin
          check(!dqOutEn, "R5 bus released on read", dqOutEn, 0);
        end
      end
      if (!prevCas && colStrobeN)
        check(cyc == acceptAt + RD_LAT, "R8 column width", cyc, acceptAt + RD_LAT);
      if (inFlight && curWr && !outEnN)
        check(0, "R5 output enable high in write", outEnN, 1);
      if (inFlight && !curWr && !colStrobeN)
        check(!outEnN, "R6 output enable low in read", outEnN, 0);
      if (rdValid) begin
        check(!curWr, "R6 no valid on write", curWr, 0);
        check(rdData == curData, "R6 read data", rdData, curData);
        check(cyc == acceptAt + RD_LAT, "R6 read latency", cyc, acceptAt + RD_LAT);
      end
      if (inFlight && !prevReady && reqReady)
        check(cyc == acceptAt + RD_LAT + TPRE, "R7 ready after precharge", cyc,
              acceptAt + RD_LAT + TPRE);
      if (reqValid && reqReady) begin
        prevAcceptAt = acceptAt;
        acceptAt = cyc + 1;
        lastGap  = acceptAt - prevAcceptAt;
        curWr    = reqWrite;
        curAddr  = reqAddr;
        curData  = reqWdata;
        inFlight = 1;
        accFlag  = 1;
      end else begin
        accFlag = 0;
      end
    end
    prevRas   = rowStrobeN;
    prevCas   = colStrobeN;
    prevReady = reqReady;
    prevAddr  = memAddr;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk);
    reqValid <= 1'b1;
    reqWrite <= wr;
    reqAddr  <= a;
    reqWdata <= d;
    do @(posedge clk); while (!accFlag);
    reqValid <= 1'b0;
  endtask

  task automatic waitReady();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rowStrobeN && colStrobeN && writeEnN && outEnN, "R1 strobes high",
          {rowStrobeN, colStrobeN, writeEnN, outEnN}, 4'hF);
    check(!dqOutEn && !rdValid && reqReady, "R1 bus free and ready",
          {dqOutEn, rdValid, reqReady}, 3'b001);

    // Vector table walk (R2..R8 checked by the monitor)
    for (int v = 0; v < NVEC; v++) begin
      issue(VECS[v][24], VECS[v][23:16], VECS[v][15:0]);
      waitReady();
    end

    // R7: back-to-back with valid held high
    @(posedge clk);
    reqValid <= 1'b1; reqWrite <= 1'b0; reqAddr <= 8'hFF; reqWdata <= 16'hBEEF;
    do @(posedge clk); while (!accFlag);
    reqAddr <= 8'h00; reqWdata <= 16'h1234;
    do @(posedge clk); while (!accFlag);
    reqValid <= 1'b0;
    check(lastGap == GAP, "R7 back-to-back spacing", lastGap, GAP);
    waitReady();

    // R1: reset in the middle of a read column pulse
    issue(1'b0, 8'h11, 16'h0000);
    @(negedge clk);
    while (colStrobeN) @(negedge clk);
    @(posedge clk);
    rst <= 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rowStrobeN && colStrobeN && writeEnN && outEnN, "R1 strobes high after mid reset",
          {rowStrobeN, colStrobeN, writeEnN, outEnN}, 4'hF);
    check(!dqOutEn && !rdValid && reqReady, "R1 idle after mid reset",
          {dqOutEn, rdValid, reqReady}, 3'b001);
    @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    check(reqReady && rowStrobeN, "R1 ready after reset release", reqReady, 1);

    // Access works again after the interrupted one
    issue(1'b0, 8'hA5, 16'hF0F0);
    waitReady();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule